// File: doc/BRIEF.md
# Core Interrupt Pending and Compare-Timer Unit

This unit gathers the interrupt sources of a 32-bit RISC core and turns them into one request line. Six external device inputs and two auxiliary inputs are collected into an eight-bit pending field of a cause register. A status register holds a global enable and an eight-bit mask. The request to the core is raised only when an unmasked pending bit exists, the global enable is on, and the core is not in its exception, error or debug mode.

The unit also carries a 32-bit counter that advances on a tick-enable input, and a 32-bit compare register. When a tick moves the counter onto the compare value, a sticky timer flag is raised. It shares the highest interrupt line with device input 5 and stays up until software writes the compare register. A 4-bit free-running value can be read as a pseudo-random index.

Software reaches the registers through a single-cycle register-select port. A write takes effect at the clock edge where `reg_wr_i` is high. A read is combinational from `reg_sel_i`. The port is always ready and has no back-pressure and no valid/ready handshake, because every access completes in one cycle.

Top module: `core_intc`

## Requirements
- R1: After reset, status, cause, count and compare all read as zero, and `irq_req_o` is low.
- R2: Selector codes are 0 status, 1 cause, 2 count, 3 compare and 4 random. Auxiliary input j sets cause bit 8+j. Device input k sets cause bit 10+k. Device input 5 and the timer flag share cause bit 15.
- R3: A pending bit follows its input level. It appears in cause two clock edges at most after the input changes, and it clears the same way when the input drops.
- R4: `irq_req_o` is high only when status bit 0 is set and some cause bit 8+n is set together with status bit 8+n.
- R5: `irq_req_o` is held low whenever `exl_i`, `erl_i` or `dbg_i` is high.
- R6: Count adds one on every clock edge where `tick_i` is high and wraps modulo 2^32. A count write loads the written value instead.
- R7: A tick that advances count to equal compare sets the timer flag, shown at cause bit 15. The flag stays set while count keeps running. Loading count with the compare value does not set it.
- R8: Any write to compare clears the timer flag, and the next tick that reaches the new compare value sets it again.
- R9: The random register reads a 4-bit value in bits 3:0 that increases by one each clock modulo 16. Bits 31:4 read zero.
- R10: Only status bits 15:8 and 0 are writable, and other status bits read zero. Writes to cause and to unused selectors (5 to 7) change nothing, and unused selectors read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_irq_i | input | 6 | Device interrupt levels, input k on line k+2 |
| aux_irq_i | input | 2 | Auxiliary interrupt levels on lines 0 and 1 |
| tick_i | input | 1 | Count advance enable |
| exl_i | input | 1 | Core is at exception level |
| erl_i | input | 1 | Core is at error level |
| dbg_i | input | 1 | Core is in debug mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register selector |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
The bench drives count across the 2^32 wrap so that the match lands one tick after wrapping. A design that compares before the increment, or that mishandles the carry, would fire a tick early or not at all. It then keeps ticking past the match and checks that the flag stays up, which a level-only comparator would drop. It writes compare and then reaches the new value again, so a flag that never re-arms shows up. It also loads count with the compare value, which must not fire. Random mixes of masks, line levels and mode flags are checked against a reference gating function: a missing mode block, or an off-by-two line mapping, would show up as a wrong request or a wrong cause readback.

// File: rtl/core_intc_pkg.sv
package core_intc_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned N_LINES   = 8;
  localparam int unsigned FIELD_LSB = 8;
  localparam int unsigned AUX_W     = 2;
  localparam int unsigned DEV_W     = N_LINES - AUX_W;
  localparam int unsigned RAND_W    = 4;
  localparam int unsigned SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS  = 3'd0,
    SEL_CAUSE   = 3'd1,
    SEL_COUNT   = 3'd2,
    SEL_COMPARE = 3'd3,
    SEL_RANDOM  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/intc_timer.sv
module intc_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         cnt_wr_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] compare_o,
  output logic         fire_o
);
  logic [W-1:0] cnt_q, cmp_q, cnt_inc;
  logic         flag_q;

  assign cnt_inc = cnt_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_wr_i)     cnt_q <= wdata_i;
      else if (tick_i)  cnt_q <= cnt_inc;
      if (cmp_wr_i)     cmp_q <= wdata_i;
      if (cmp_wr_i)
        flag_q <= 1'b0;
      else if (tick_i && !cnt_wr_i && (cnt_inc == cmp_q))
        flag_q <= 1'b1;
    end
  end

  assign count_o   = cnt_q;
  assign compare_o = cmp_q;
  assign fire_o    = flag_q;

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i) |=> (cnt_q == $past(cnt_q) + W'(1)));
  // R8
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_i |=> !flag_q);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !cmp_wr_i) |=> flag_q);
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int unsigned N     = 8,
  parameter int unsigned AUX   = 2,
  parameter int unsigned TLINE = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AUX-1:0] aux_i,
  input  logic [N-AUX-1:0] dev_i,
  input  logic           timer_i,
  output logic [N-1:0]   pend_o
);
  logic [N-1:0] line;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (i < AUX) begin : g_aux
      assign line[i] = aux_i[i];
    end else if (i == TLINE) begin : g_tmr
      assign line[i] = dev_i[i-AUX] | timer_i;
    end else begin : g_dev
      assign line[i] = dev_i[i-AUX];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[i] <= 1'b0;
      else        pend_o[i] <= line[i];
    end
  end

  // R7
  timer_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_i |=> pend_o[TLINE]);
  // R3
  quiet_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((aux_i == '0) && (dev_i == '0) && !timer_i) |=> (pend_o == '0));
endmodule

// File: rtl/intc_gate.sv
module intc_gate #(
  parameter int unsigned N = 8
) (
  input  logic         ie_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] pend_i,
  input  logic         exl_i,
  input  logic         erl_i,
  input  logic         dbg_i,
  output logic         req_o
);
  logic hit, blocked;
  assign hit     = |(mask_i & pend_i);
  assign blocked = exl_i | erl_i | dbg_i;
  assign req_o   = ie_i & hit & ~blocked;
endmodule

// File: rtl/intc_random.sv
module intc_random #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_o <= '0;
    else        val_o <= val_o + W'(1);
  end
endmodule

// File: rtl/core_intc.sv
module core_intc
  import core_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DEV_W-1:0]     dev_irq_i,
  input  logic [AUX_W-1:0]     aux_irq_i,
  input  logic                 tick_i,
  input  logic                 exl_i,
  input  logic                 erl_i,
  input  logic                 dbg_i,
  input  logic                 reg_wr_i,
  input  logic [SEL_W-1:0]     reg_sel_i,
  input  logic [XLEN-1:0]      reg_wdata_i,
  output logic [XLEN-1:0]      reg_rdata_o,
  output logic                 irq_req_o
);
  localparam int unsigned TIMER_LINE = N_LINES - 1;
  localparam int unsigned HI_PAD     = XLEN - FIELD_LSB - N_LINES;

  reg_sel_e            sel;
  logic                ie_q;
  logic [N_LINES-1:0]  mask_q, pend;
  logic [XLEN-1:0]     count, compare;
  logic                fire;
  logic [RAND_W-1:0]   rnd;
  logic                wr_status, wr_count, wr_compare;

  assign sel        = reg_sel_e'(reg_sel_i);
  assign wr_status  = reg_wr_i && (sel == SEL_STATUS);
  assign wr_count   = reg_wr_i && (sel == SEL_COUNT);
  assign wr_compare = reg_wr_i && (sel == SEL_COMPARE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '0;
    end else if (wr_status) begin
      ie_q   <= reg_wdata_i[0];
      mask_q <= reg_wdata_i[FIELD_LSB +: N_LINES];
    end
  end

  intc_timer #(.W(XLEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .cnt_wr_i(wr_count), .cmp_wr_i(wr_compare), .wdata_i(reg_wdata_i),
    .count_o(count), .compare_o(compare), .fire_o(fire)
  );

  intc_pending #(.N(N_LINES), .AUX(AUX_W), .TLINE(TIMER_LINE)) u_pend (
    .clk(clk), .rst_n(rst_n), .aux_i(aux_irq_i), .dev_i(dev_irq_i),
    .timer_i(fire), .pend_o(pend)
  );

  intc_gate #(.N(N_LINES)) u_gate (
    .ie_i(ie_q), .mask_i(mask_q), .pend_i(pend),
    .exl_i(exl_i), .erl_i(erl_i), .dbg_i(dbg_i), .req_o(irq_req_o)
  );

  intc_random #(.W(RAND_W)) u_rand (.clk(clk), .rst_n(rst_n), .val_o(rnd));

  always_comb begin
    case (sel)
      SEL_STATUS:  reg_rdata_o = {{HI_PAD{1'b0}}, mask_q, {(FIELD_LSB-1){1'b0}}, ie_q};
      SEL_CAUSE:   reg_rdata_o = {{HI_PAD{1'b0}}, pend, {FIELD_LSB{1'b0}}};
      SEL_COUNT:   reg_rdata_o = count;
      SEL_COMPARE: reg_rdata_o = compare;
      SEL_RANDOM:  reg_rdata_o = {{(XLEN-RAND_W){1'b0}}, rnd};
      default:     reg_rdata_o = '0;
    endcase
  end

  // R5
  mode_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exl_i || erl_i || dbg_i) |-> !irq_req_o);
  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq_req_o);
  // R4
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & pend) == '0) |-> !irq_req_o);
  // R9
  rand_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_RANDOM) |-> (reg_rdata_o[XLEN-1:RAND_W] == '0));
endmodule

// File: tb/core_intc_tb.sv
module core_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  dev = '0;
  logic [1:0]  aux = '0;
  logic        tick = 1'b0, exl = 1'b0, erl = 1'b0, dbg = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  core_intc u_dut (
    .clk(clk), .rst_n(rst_n), .dev_irq_i(dev), .aux_irq_i(aux),
    .tick_i(tick), .exl_i(exl), .erl_i(erl), .dbg_i(dbg),
    .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_req_o(irq)
  );

  function automatic logic exp_req(logic [31:0] st, logic [7:0] pend,
                                   logic e, logic r, logic d);
    return st[0] && ((st[15:8] & pend) != 8'h0) && !e && !r && !d;
  endfunction

  function automatic logic [31:0] exp_cause(logic [5:0] dv, logic [1:0] ax, logic tf);
    logic [7:0] p;
    p = {dv[5] | tf, dv[4:0], ax};
    return {16'h0, p, 8'h0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] s, logic [31:0] d);
    @(negedge clk); wr = 1'b1; sel = s; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [2:0] s, output logic [31:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, st;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rreg(3'd0, v); chk("R1 status", v, 32'h0);
    rreg(3'd1, v); chk("R1 cause", v, 32'h0);
    rreg(3'd2, v); chk("R1 count", v, 32'h0);
    rreg(3'd3, v); chk("R1 compare", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R10 writable status bits, cause and unused selectors ignore writes
    wreg(3'd0, 32'hFFFF_FFFF);
    rreg(3'd0, v); chk("R10 status mask", v, 32'h0000_FF01);
    wreg(3'd1, 32'hFFFF_FFFF); settle();
    rreg(3'd1, v); chk("R10 cause write ignored", v, 32'h0);
    wreg(3'd5, 32'h1234_5678);
    rreg(3'd5, v); chk("R10 unused read zero", v, 32'h0);
    rreg(3'd2, v); chk("R10 unused write no count", v, 32'h0);
    rreg(3'd3, v); chk("R10 unused write no compare", v, 32'h0);
    wreg(3'd0, 32'h0);

    // R9 random register
    @(negedge clk);
    rreg(3'd4, v);
    @(negedge clk);
    rreg(3'd4, v2);
    chk("R9 upper zero", {v[31:4], 4'h0}, 32'h0);
    chk("R9 step", {28'h0, v2[3:0]}, {28'h0, v[3:0] + 4'd1});

    // R2 R3 R4 R5 random mix of lines, masks and modes
    for (int i = 0; i < 60; i++) begin
      st = $urandom() & 32'h0000_FF01;
      wreg(3'd0, st);
      @(negedge clk);
      dev = 6'($urandom());
      aux = 2'($urandom());
      exl = ($urandom() % 5) == 0;
      erl = ($urandom() % 6) == 0;
      dbg = ($urandom() % 7) == 0;
      settle();
      rreg(3'd1, v);
      chk("R2 cause map", v, exp_cause(dev, aux, 1'b0));
      chk("R4 R5 request", {31'h0, irq}, {31'h0, exp_req(st, v[15:8], exl, erl, dbg)});
    end
    @(negedge clk);
    dev = '0; aux = '0; exl = 0; erl = 0; dbg = 0;
    settle();
    rreg(3'd1, v); chk("R3 level clears", v, 32'h0);
    chk("R3 irq drops", {31'h0, irq}, 32'h0);

    // R6 R7 wrap then match
    wreg(3'd0, 32'h0);
    wreg(3'd3, 32'h0000_0001);
    wreg(3'd2, 32'hFFFF_FFFE);
    ticks(2);
    rreg(3'd2, v); chk("R6 wrap", v, 32'h0);
    settle();
    rreg(3'd1, v); chk("R7 no early fire", v, 32'h0);
    ticks(1);
    settle();
    rreg(3'd1, v); chk("R7 match sets bit15", v, 32'h0000_8000);
    ticks(5);
    settle();
    rreg(3'd2, v); chk("R6 count runs", v, 32'h6);
    rreg(3'd1, v); chk("R7 sticky", v, 32'h0000_8000);

    // R4 R5 with the timer line
    wreg(3'd0, 32'h0000_8001); @(negedge clk);
    chk("R4 timer request", {31'h0, irq}, 32'h1);
    wreg(3'd0, 32'h0000_0001); @(negedge clk);
    chk("R4 masked", {31'h0, irq}, 32'h0);
    wreg(3'd0, 32'h0000_8000); @(negedge clk);
    chk("R4 disabled", {31'h0, irq}, 32'h0);
    wreg(3'd0, 32'h0000_8001);
    @(negedge clk); exl = 1; #1; chk("R5 exl", {31'h0, irq}, 32'h0);
    exl = 0; erl = 1; #1; chk("R5 erl", {31'h0, irq}, 32'h0);
    erl = 0; dbg = 1; #1; chk("R5 dbg", {31'h0, irq}, 32'h0);
    dbg = 0; #1; chk("R5 released", {31'h0, irq}, 32'h1);

    // R8 compare write clears and re-arms
    wreg(3'd3, 32'h0000_0010);
    settle();
    rreg(3'd1, v); chk("R8 cleared", v, 32'h0);
    chk("R8 irq low", {31'h0, irq}, 32'h0);
    ticks(9);
    settle();
    rreg(3'd1, v); chk("R8 before rearm", v, 32'h0);
    ticks(1);
    settle();
    rreg(3'd1, v); chk("R8 rearmed", v, 32'h0000_8000);
    chk("R8 irq again", {31'h0, irq}, 32'h1);

    // R7 loading count onto compare does not fire
    wreg(3'd3, 32'h0000_0020);
    wreg(3'd2, 32'h0000_0020);
    settle();
    rreg(3'd1, v); chk("R7 load no fire", v, 32'h0);
    rreg(3'd2, v); chk("R6 count load", v, 32'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule